// File: doc/BRIEF.md
# Substitution Table Lookup Unit

This unit answers substitution-table reads for cipher kernels. It keeps local copies of up to four tables. Each table has 256 entries of 32 bits and starts on a 1 KiB boundary in memory. A lookup names a table by a base register and picks the index byte out of a second operand. The entry's memory address is formed with no adder: base bits 31:10, then the 8-bit index, then two zero bits.

Stores to table memory are deliberately not seen by later lookups. A copy is refreshed only when a sync command names its table, or when a snooped store to that table has set the table's alias flag. A lookup to a table that is not resident allocates a slot. Slots are reused in the order they were allocated. The lookup then waits while the table is read in over a simple word-read port.

The refill controller is a three-state machine. `FS_IDLE` waits for a start, which is either an accepted sync or a lookup that misses or hits an aliased slot. The start moves it to `FS_ISSUE`. `FS_ISSUE` sends one read per cycle for indices 0 to 255 and moves to `FS_LAST` after index 255. `FS_LAST` writes the final word and always returns to `FS_IDLE`.

Top module: `subst_lookup_unit`

## Requirements
- R1: After reset, no table is resident. `lk_ready`, `rd_valid`, `mem_req` and `fill_busy` are all low.
- R2: During a refill, `mem_addr` equals {base[31:10], index, 2'b00}, with the index going 0 to 255 in ascending order, one per cycle. Read data is taken from `mem_rdata` one cycle after each `mem_req`.
- R3: The lookup index is byte lane `lk_lane` of `lk_operand`. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24. Base bits 9:0 are ignored.
- R4: A lookup accepted (`lk_valid` and `lk_ready`) on a resident, non-aliased table gives `rd_valid` with the entry on `rd_data` in the next cycle. It makes no memory read.
- R5: A lookup whose base matches no slot refills a slot with exactly 256 reads. `fill_busy` is high and `lk_ready` is low throughout. `lk_ready` rises 258 cycles after the lookup is first presented.
- R6: A store to table memory that is not snooped does not change values returned by later lookups.
- R7: A sync (`sync_valid` while `fill_busy` is low) refills the named table with 256 reads, so later lookups return the stored data. A sync to a non-resident base allocates a slot for it.
- R8: A snooped store whose address bits 31:10 match a resident table sets that table's alias flag. The next lookup to that table refills it first (258-cycle wait) and then returns the new data. A snoop to a non-resident base has no effect.
- R9: With all four slots in use, a miss evicts the slot that was allocated earliest. Refreshes do not change that order.
- R10: When a sync and a lookup arrive in the same idle cycle, the sync wins and the lookup is not accepted that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_base | input | 32 | Table base register |
| lk_operand | input | 32 | Operand holding the index byte |
| lk_lane | input | 2 | Byte lane of the operand used as index |
| lk_ready | output | 1 | Lookup accepted this cycle if valid |
| rd_valid | output | 1 | Lookup result valid |
| rd_data | output | 32 | Table entry returned |
| sync_valid | input | 1 | Sync command for one table |
| sync_base | input | 32 | Base of the table to sync |
| snoop_valid | input | 1 | Observed store to memory |
| snoop_addr | input | 32 | Address of the observed store |
| fill_busy | output | 1 | A refill is in progress |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory word address |
| mem_rdata | input | 32 | Read data, one cycle after the request |

## Verification
A hit returns its entry in the cycle after acceptance. A miss, or a lookup to an aliased table, raises `lk_ready` 258 cycles after the request is first presented. Those 258 cycles are 256 read cycles, one final write cycle and the idle cycle. A sync is accepted on the next edge and refills in the same 257 busy cycles. The bench samples every output at the falling edge. It counts the wait of each lookup in falling edges and compares the count with 0 or 258. It queues each expected entry at acceptance and pops it at the first falling edge on which `rd_valid` is high. It counts read requests and checks each address against the next index in the sweep.

// File: rtl/slu_pkg.sv
package slu_pkg;

    // Refill controller states
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_LAST  = 2'd2
    } fill_state_e;

    localparam int LANE_BITS  = 8;
    localparam int LANE_COUNT = 4;
    localparam int WORD_SHIFT = 2;

endpackage

// File: rtl/slu_tag_dir.sv
module slu_tag_dir #(
    parameter int SLOTS  = 4,
    parameter int TAG_W  = 22,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [TAG_W-1:0]  sy_tag,
    input  logic              snp_valid,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              fill_start,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_alloc,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    output logic              lk_alias,
    output logic              sy_hit,
    output logic [SLOT_W-1:0] sy_slot,
    output logic [SLOT_W-1:0] victim
);

    logic [TAG_W-1:0] tag_q [SLOTS];
    logic [SLOTS-1:0] valid_q;
    logic [SLOTS-1:0] alias_q;
    logic [SLOTS-1:0] lk_match;
    logic [SLOTS-1:0] sy_match;
    logic [SLOTS-1:0] snp_match;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign lk_match[s]  = valid_q[s] && (tag_q[s] == lk_tag);
        assign sy_match[s]  = valid_q[s] && (tag_q[s] == sy_tag);
        assign snp_match[s] = valid_q[s] && (tag_q[s] == snp_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[s]   <= '0;
                valid_q[s] <= 1'b0;
                alias_q[s] <= 1'b0;
            end else begin
                if (fill_start && fill_slot == SLOT_W'(s)) begin
                    tag_q[s]   <= fill_tag;
                    valid_q[s] <= 1'b1;
                end
                // a store seen in the same cycle wins over the clear
                if (snp_valid && snp_match[s])
                    alias_q[s] <= 1'b1;
                else if (fill_start && fill_slot == SLOT_W'(s))
                    alias_q[s] <= 1'b0;
            end
        end

        // R8: an alias flag only rises after a matching snooped store
        p_alias_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alias_q[s]) |-> $past(snp_valid));
    end

    function automatic logic [SLOT_W-1:0] enc(input logic [SLOTS-1:0] vec);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = 0; i < SLOTS; i++)
            if (vec[i]) r = SLOT_W'(i);
        return r;
    endfunction

    always_comb begin
        lk_hit   = |lk_match;
        lk_slot  = enc(lk_match);
        lk_alias = |(lk_match & alias_q);
        sy_hit   = |sy_match;
        sy_slot  = enc(sy_match);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            victim <= '0;
        else if (fill_alloc)
            victim <= (victim == SLOT_W'(SLOTS - 1)) ? '0 : victim + 1'b1;
    end

    // R9: a table is resident in at most one slot
    p_unique_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

endmodule

// File: rtl/slu_fill_fsm.sv
module slu_fill_fsm
    import slu_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 22,
    parameter int SLOT_W  = 2,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [SLOT_W-1:0] start_slot,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [IDX_W-1:0]  wr_idx
);

    fill_state_e      state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic [TAG_W-1:0] tag_q;
    logic [SLOT_W-1:0] slot_q;
    logic             wr_pend_q;
    logic [IDX_W-1:0] wr_idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (start) state_d = FS_ISSUE;
            FS_ISSUE: if (cnt_q == IDX_W'(ENTRIES - 1)) state_d = FS_LAST;
            FS_LAST:  state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    // sweep datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            tag_q     <= '0;
            slot_q    <= '0;
            wr_pend_q <= 1'b0;
            wr_idx_q  <= '0;
        end else begin
            wr_pend_q <= (state_q == FS_ISSUE);
            wr_idx_q  <= cnt_q;
            if (state_q == FS_IDLE && start) begin
                cnt_q  <= '0;
                tag_q  <= start_tag;
                slot_q <= start_slot;
            end else if (state_q == FS_ISSUE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != FS_IDLE);
        mem_req  = (state_q == FS_ISSUE);
        mem_addr = {tag_q, cnt_q, {WORD_SHIFT{1'b0}}};
        wr_en    = wr_pend_q;
        wr_slot  = slot_q;
        wr_idx   = wr_idx_q;
    end

    // R2: consecutive reads step the index by one with a fixed table base
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |->
            (mem_addr[IDX_W+1:2] == $past(mem_addr[IDX_W+1:2]) + 1'b1) &&
            (mem_addr[ADDR_W-1:IDX_W+2] == $past(mem_addr[ADDR_W-1:IDX_W+2])));

    // R5: a sweep ends only after the last index was read
    p_sweep_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> ($past(mem_addr[IDX_W+1:2]) == IDX_W'(ENTRIES - 1)));

    // R2: a read request is followed by a write of its data
    p_write_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> wr_en);

endmodule

// File: rtl/slu_table_ram.sv
module slu_table_ram #(
    parameter int SLOTS   = 4,
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 32,
    parameter int SLOT_W  = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int DEPTH  = SLOTS * ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            store_q[{wr_slot, wr_idx}] <= wr_data;
        if (rd_en)
            rd_data <= store_q[{rd_slot, rd_idx}];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end

endmodule

// File: rtl/subst_lookup_unit.sv
module subst_lookup_unit
    import slu_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_base,
    input  logic [DATA_W-1:0] lk_operand,
    input  logic [1:0]        lk_lane,
    output logic              lk_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sync_valid,
    input  logic [ADDR_W-1:0] sync_base,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              fill_busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int TAG_LSB = IDX_W + WORD_SHIFT;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [TAG_W-1:0]  lk_tag, sy_tag, snp_tag, fill_tag;
    logic [IDX_W-1:0]  lk_idx;
    logic [DATA_W-1:0] lane_shifted;
    logic              lk_hit, lk_alias, sy_hit;
    logic [SLOT_W-1:0] lk_slot, sy_slot, victim, fill_slot;
    logic              start_sync, start_lk, fill_start, fill_alloc, idle;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [IDX_W-1:0]  wr_idx;
    logic              accept;
    logic              unused_low_bits;

    assign lk_tag  = lk_base[ADDR_W-1:TAG_LSB];
    assign sy_tag  = sync_base[ADDR_W-1:TAG_LSB];
    assign snp_tag = snoop_addr[ADDR_W-1:TAG_LSB];
    assign unused_low_bits = ^{lk_base[TAG_LSB-1:0], sync_base[TAG_LSB-1:0],
                               snoop_addr[TAG_LSB-1:0]};

    // byte lane select: the index byte comes from the chosen lane
    assign lane_shifted = lk_operand >> {lk_lane, 3'b000};
    assign lk_idx       = lane_shifted[IDX_W-1:0];

    slu_tag_dir #(.SLOTS(SLOTS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) i_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (lk_tag),
        .sy_tag     (sy_tag),
        .snp_valid  (snoop_valid),
        .snp_tag    (snp_tag),
        .fill_start (fill_start),
        .fill_slot  (fill_slot),
        .fill_tag   (fill_tag),
        .fill_alloc (fill_alloc),
        .lk_hit     (lk_hit),
        .lk_slot    (lk_slot),
        .lk_alias   (lk_alias),
        .sy_hit     (sy_hit),
        .sy_slot    (sy_slot),
        .victim     (victim)
    );

    // start decision: sync first, then a lookup that cannot be served
    always_comb begin
        idle       = !fill_busy;
        start_sync = sync_valid && idle;
        start_lk   = lk_valid && idle && !sync_valid && !(lk_hit && !lk_alias);
        fill_start = start_sync || start_lk;
        fill_tag   = start_sync ? sy_tag : lk_tag;
        if (start_sync)
            fill_slot = sy_hit ? sy_slot : victim;
        else
            fill_slot = lk_hit ? lk_slot : victim;
        fill_alloc = fill_start && !(start_sync ? sy_hit : lk_hit);
        lk_ready   = idle && !sync_valid && lk_hit && !lk_alias;
        accept     = lk_valid && lk_ready;
    end

    slu_fill_fsm #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .SLOT_W(SLOT_W),
                   .ADDR_W(ADDR_W)) i_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fill_start),
        .start_tag  (fill_tag),
        .start_slot (fill_slot),
        .busy       (fill_busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_idx     (wr_idx)
    );

    slu_table_ram #(.SLOTS(SLOTS), .ENTRIES(ENTRIES), .DATA_W(DATA_W),
                    .SLOT_W(SLOT_W)) i_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_idx   (wr_idx),
        .wr_data  (mem_rdata),
        .rd_en    (accept),
        .rd_slot  (lk_slot),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R4: every accepted lookup returns a result on the next cycle
    p_result_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rd_valid);

    // R4: no result without an accepted lookup
    p_result_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(lk_valid && lk_ready));

    // R5: lookups are held off while a refill runs
    p_stall_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> !lk_ready);

    // R4: a served lookup makes no memory read
    p_hit_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |-> !mem_req);

endmodule

// File: tb/test_subst_lookup_unit.sv
`timescale 1ns/1ps
module test_subst_lookup_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_base = '0;
    logic [31:0] lk_operand = '0;
    logic [1:0]  lk_lane = '0;
    logic        lk_ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        sync_valid = 1'b0;
    logic [31:0] sync_base = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        fill_busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    subst_lookup_unit i_subst_lookup_unit (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model
    logic [31:0] mem_over [int unsigned];
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int unsigned k = int'(a >> 2);
        if (mem_over.exists(k)) return mem_over[k];
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) mem_rdata <= mem_req ? mem_word(mem_addr) : 32'h0;

    // requirement-level model of resident tables
    logic [21:0] m_tag [4];
    bit          m_val [4];
    bit          m_alias [4];
    int          m_ptr = 0;
    logic [31:0] vis [int unsigned];
    logic [21:0] fill_tag_exp = '0;
    int          fill_idx_exp = 0;
    int          addr_err = 0;
    int          req_cnt = 0;

    function automatic int m_find(input logic [21:0] t);
        for (int s = 0; s < 4; s++)
            if (m_val[s] && m_tag[s] == t) return s;
        return -1;
    endfunction

    function automatic void m_refill(input logic [21:0] t);
        int s = m_find(t);
        if (s < 0) begin
            s = m_ptr;
            m_tag[s] = t;
            m_val[s] = 1'b1;
            m_ptr = (m_ptr + 1) % 4;
        end
        m_alias[s] = 1'b0;
        for (int i = 0; i < 256; i++)
            vis[{2'b00, t, 8'(i)}] = mem_word({t, 8'(i), 2'b00});
        fill_tag_exp = t;
        fill_idx_exp = 0;
    endfunction

    // address monitor for refill sweeps
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            req_cnt++;
            if (mem_addr != {fill_tag_exp, 8'(fill_idx_exp), 2'b00}) addr_err++;
            fill_idx_exp++;
        end
    end

    // scoreboard
    logic [31:0] exp_q [$];
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected result", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R4/R3 lookup data", rd_data, e);
            end
        end
    end

    task automatic do_lookup(input logic [31:0] base, input logic [31:0] opnd,
                             input logic [1:0] lane, input string req);
        logic [21:0] t;
        logic [7:0]  idx;
        int          s, waits, start_req, exp_wait;
        bit          need;
        t   = base[31:10];
        idx = 8'(opnd >> (8 * lane));
        s   = m_find(t);
        need = (s < 0) || m_alias[s];
        @(negedge clk);
        start_req = req_cnt;
        addr_err  = 0;
        if (need) m_refill(t);
        exp_wait = need ? 258 : 0;
        lk_valid = 1'b1; lk_base = base; lk_operand = opnd; lk_lane = lane;
        waits = 0;
        #1;
        while (!lk_ready && waits < 2000) begin
            @(negedge clk); #1;
            waits++;
        end
        exp_q.push_back(vis[{2'b00, t, idx}]);
        @(posedge clk); #1;
        lk_valid = 1'b0;
        @(negedge clk);
        check(waits == exp_wait, {req, " wait cycles"}, 32'(waits), 32'(exp_wait));
        check(req_cnt - start_req == (need ? 256 : 0), {req, " read count"},
              32'(req_cnt - start_req), need ? 32'd256 : 32'd0);
        if (need) check(addr_err == 0, "R2 refill address", 32'(addr_err), 32'd0);
    endtask

    task automatic do_sync(input logic [31:0] base, input string req);
        int start_req;
        @(negedge clk);
        start_req = req_cnt;
        addr_err  = 0;
        m_refill(base[31:10]);
        sync_valid = 1'b1; sync_base = base;
        @(posedge clk); #1;
        sync_valid = 1'b0;
        while (fill_busy) @(negedge clk);
        check(req_cnt - start_req == 256, {req, " sync read count"},
              32'(req_cnt - start_req), 32'd256);
        check(addr_err == 0, "R2 sync address", 32'(addr_err), 32'd0);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                            input bit snoop);
        @(negedge clk);
        mem_over[int'(a >> 2)] = d;
        if (snoop) begin
            snoop_valid = 1'b1; snoop_addr = a;
            @(posedge clk); #1;
            snoop_valid = 1'b0;
            for (int s = 0; s < 4; s++)
                if (m_val[s] && m_tag[s] == a[31:10]) m_alias[s] = 1'b1;
        end
    endtask

    localparam logic [31:0] TA = 32'h0001_0123;
    localparam logic [31:0] TB = 32'h0002_0000;
    localparam logic [31:0] TC = 32'h0003_0000;
    localparam logic [31:0] TD = 32'h0004_0000;
    localparam logic [31:0] TE = 32'h0005_0000;
    localparam logic [31:0] TF = 32'h0006_0000;
    bit done = 0;

    initial begin
        for (int s = 0; s < 4; s++) begin m_val[s] = 0; m_alias[s] = 0; m_tag[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!lk_ready, "R1 lk_ready", 32'(lk_ready), 0);
        check(!rd_valid, "R1 rd_valid", 32'(rd_valid), 0);
        check(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        check(!fill_busy, "R1 fill_busy", 32'(fill_busy), 0);

        do_lookup(TA, 32'h0000_0000, 2'd0, "R5 miss");          // refill A, index 0
        do_lookup(TA, 32'hFF12_3456, 2'd3, "R3 lane3 idx255");  // index 0xFF
        do_lookup(TA, 32'h0000_7A00, 2'd1, "R3 lane1");
        do_lookup(TA, 32'h0042_0000, 2'd2, "R3 lane2");
        // R6 hidden store
        do_store(32'h0001_0014, 32'hDEAD_BEEF, 1'b0);
        do_lookup(TA, 32'h0000_0005, 2'd0, "R6 hidden");
        // R7 sync makes it visible
        do_sync(TA, "R7");
        do_lookup(TA, 32'h0000_0005, 2'd0, "R7 after sync");
        // fill remaining slots
        do_lookup(TB, 32'h0000_0001, 2'd0, "R5 fill B");
        do_lookup(TC, 32'h0000_0002, 2'd0, "R5 fill C");
        do_lookup(TD, 32'h0000_0003, 2'd0, "R5 fill D");
        // R8 snooped store to C forces a refresh
        do_store(32'h0003_0020, 32'h1234_ABCD, 1'b1);
        do_lookup(TC, 32'h0000_0008, 2'd0, "R8 alias refresh");
        // R8 snoop to non-resident base has no effect
        do_store(32'h0007_0000, 32'h0BAD_0BAD, 1'b1);
        do_lookup(TA, 32'h0000_0005, 2'd0, "R8 foreign snoop");
        // R9 allocation order: E evicts A, B stays, A evicts B
        do_lookup(TE, 32'h0000_0009, 2'd0, "R9 evict oldest");
        do_lookup(TB, 32'h0000_0001, 2'd0, "R9 B kept");
        do_lookup(TA, 32'h0000_0005, 2'd0, "R9 A refetched");
        // R10 sync wins over a same-cycle lookup
        @(negedge clk);
        sync_valid = 1'b1; sync_base = TF;
        lk_valid = 1'b1; lk_base = TC; lk_operand = 32'h8; lk_lane = 2'd0;
        #1;
        check(!lk_ready, "R10 lookup held", 32'(lk_ready), 0);
        @(posedge clk); #1;
        sync_valid = 1'b0; lk_valid = 1'b0;
        addr_err = 0;
        m_refill(TF[31:10]);
        @(negedge clk);
        check(fill_busy, "R10 sync taken", 32'(fill_busy), 1);
        while (fill_busy) @(negedge clk);
        check(addr_err == 0, "R2 sync F address", 32'(addr_err), 0);
        // R7 sync allocated F: lookup hits without waiting
        do_lookup(TF, 32'h0000_00AB, 2'd0, "R7 sync allocate");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 results drained", 32'(exp_q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule